// File: doc/BRIEF.md
# Background multiply/divide unit with read interlock

This unit sits beside an integer pipeline and runs multiply and divide commands in the background. It handles signed and unsigned forms in two widths: a 32-bit single form and a 64-bit doubleword form. The issuing side hands over a command in one cycle and is never held at issue. Later instructions keep flowing while the unit works.

Each command writes two 64-bit result registers, hi and lo. A multiply puts the upper half of its double-width product in hi and the lower half in lo. A divide puts the quotient in lo and the remainder in hi.

Every operation class has a fixed latency, and results become visible only when that latency has elapsed. A read of hi or lo requested during that window holds the stall output high until the result lands, and then returns the new value. A read while the unit is idle is served in the same cycle. A command issued while the unit is busy abandons the running operation and starts its own latency count.

Top module: `mdu_core`

## Requirements
- R1: After reset, busy_o and stall_o are low, and both hi and lo read as zero.
- R2: The encoding of cmd_op_i is as follows. Bit 2 set selects the doubleword form, bit 1 set selects divide (clear selects multiply), and bit 0 set selects unsigned. The 32-bit forms use only bits 31:0 of each operand and ignore bits 63:32.
- R3: busy_o rises on the cycle after the issuing clock edge. It stays high for exactly 12 cycles for a 32-bit multiply, 20 for a doubleword multiply, 75 for a 32-bit divide and 139 for a doubleword divide. The new hi and lo values are readable on the first cycle that busy_o is low.
- R4: A 32-bit multiply writes bits 63:32 of the 64-bit product to hi and bits 31:0 to lo. Each half is sign-extended to 64 bits.
- R5: A doubleword multiply writes bits 127:64 of the 128-bit product to hi and bits 63:0 to lo.
- R6: A divide writes the quotient to lo and the remainder to hi. A signed divide truncates toward zero, and its remainder takes the sign of the dividend. For a 32-bit divide, both 32-bit results are sign-extended to 64 bits.
- R7: While busy_o is high, a read request (rd_req_i) drives stall_o high in the same cycle, and stall_o stays high until busy_o drops. rd_data_o then returns the new value of the selected register (rd_sel_i=1 selects hi, 0 selects lo).
- R8: While busy_o is low, a read request never stalls, and rd_data_o shows the selected register in the same cycle.
- R9: Issuing a command does not stall. With no read request, stall_o stays low throughout a busy period.
- R10: A command issued while busy_o is high aborts the running operation. The aborted result never reaches hi or lo, and busy_o then stays high for the full latency of the new command, counted from its own issue edge.
- R11: No error flag exists for a zero divisor. The command completes with the normal latency. An unsigned doubleword divide by zero leaves all ones in lo and the dividend in hi.
- R12: While busy_o is low and no command is issued, hi and lo do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Issue a command this cycle |
| cmd_op_i | input | 3 | {doubleword, divide, unsigned} |
| cmd_a_i | input | 64 | Multiplicand or dividend |
| cmd_b_i | input | 64 | Multiplier or divisor |
| rd_req_i | input | 1 | Read request for hi or lo |
| rd_sel_i | input | 1 | 1 selects hi, 0 selects lo |
| rd_data_o | output | 64 | Selected result register |
| stall_o | output | 1 | Read must wait for the running operation |
| busy_o | output | 1 | An operation is in progress |

## Verification
A wrong latency count shows up at the ports as a busy_o pulse of the wrong length. It also shows as a stall that ends early, so that a stale hi or lo value is returned on the first idle cycle. Both appear within one operation's latency of the issue edge, at most 139 cycles.

A fault in the sign handling or the step logic of either engine shows up as a wrong hi or lo value at the first idle read. Each operand set is chosen so that the sign and the half placement differ between candidate faults.

An abort that fails to reload the timer or the engine shows up as a busy period measured from the earlier issue. It can also show as the old operation's result appearing in the registers.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  parameter int unsigned XLEN      = 64;
  parameter int unsigned MUL_DIGIT = 4;   // multiplier bits consumed per step
  parameter int unsigned LAT_MUL_S = 12;
  parameter int unsigned LAT_MUL_D = 20;
  parameter int unsigned LAT_DIV_S = 75;
  parameter int unsigned LAT_DIV_D = 139;

  localparam int unsigned LAT_W = $clog2(LAT_DIV_D + 1);

  typedef struct packed {
    logic dword;
    logic is_div;
    logic uns;
  } mdu_op_t;

  function automatic logic [LAT_W-1:0] op_latency(mdu_op_t op);
    logic [LAT_W-1:0] lat;
    case ({op.dword, op.is_div})
      2'b00:   lat = LAT_W'(LAT_MUL_S);
      2'b10:   lat = LAT_W'(LAT_MUL_D);
      2'b01:   lat = LAT_W'(LAT_DIV_S);
      default: lat = LAT_W'(LAT_DIV_D);
    endcase
    return lat;
  endfunction

endpackage

// File: rtl/mdu_lat_timer.sv
module mdu_lat_timer #(
  parameter int unsigned LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [LW-1:0] lat_i,
  output logic          busy_o,
  output logic          fire_o
);

  logic [LW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  // a fresh issue on the last cycle aborts the commit
  assign fire_o = (cnt_q == LW'(1)) && !issue_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (issue_i)      cnt_q <= lat_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - LW'(1);
  end

  AST_ISSUE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && lat_i != '0) |=> busy_o); // R3
  AST_FIRE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !busy_o); // R3

endmodule

// File: rtl/mdu_mul_engine.sv
module mdu_mul_engine #(
  parameter int unsigned W   = 64,
  parameter int unsigned DIG = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           run_o,
  output logic [2*W-1:0] prod_o
);

  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] acc_q, a_sh_q, digit_ext;
  logic [W-1:0]  b_sh_q, b_next;
  logic          run_q;

  assign digit_ext = PW'(b_sh_q[DIG-1:0]);
  assign b_next    = b_sh_q >> DIG;
  assign run_o     = run_q;
  assign prod_o    = acc_q;

  // radix-2^DIG shift-add; stops once no multiplier bits remain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      a_sh_q <= '0;
      b_sh_q <= '0;
      run_q  <= 1'b0;
    end else if (start_i) begin
      acc_q  <= '0;
      a_sh_q <= PW'(a_i);
      b_sh_q <= b_i;
      run_q  <= 1'b1;
    end else if (run_q) begin
      acc_q  <= acc_q + a_sh_q * digit_ext;
      a_sh_q <= a_sh_q << DIG;
      b_sh_q <= b_next;
      run_q  <= (b_next != '0);
    end
  end

  AST_MUL_SHRINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !start_i && b_sh_q != '0) |=> (b_sh_q < $past(b_sh_q))); // R5

endmodule

// File: rtl/mdu_div_engine.sv
module mdu_div_engine #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         half_i,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         run_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);

  localparam int unsigned CW = $clog2(W + 1);
  localparam int unsigned HW = W / 2;

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic [W+1:0]  trial;

  // two guard bits keep the sign of the trial subtraction exact
  assign trial = {1'b0, rem_q, quo_q[W-1]} - {2'b00, dvs_q};
  assign run_o = (cnt_q != '0);
  assign quo_o = quo_q;
  assign rem_o = rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      rem_q <= '0;
      dvs_q <= dvs_i;
      quo_q <= half_i ? {dvd_i[HW-1:0], {HW{1'b0}}} : dvd_i;
      cnt_q <= half_i ? CW'(HW) : CW'(W);
    end else if (cnt_q != '0) begin
      if (!trial[W+1]) begin
        rem_q <= trial[W-1:0];
        quo_q <= {quo_q[W-2:0], 1'b1};
      end else begin
        rem_q <= {rem_q[W-2:0], quo_q[W-1]};
        quo_q <= {quo_q[W-2:0], 1'b0};
      end
      cnt_q <= cnt_q - CW'(1);
    end
  end

  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && dvs_q != '0) |-> (rem_q < dvs_q)); // R6

endmodule

// File: rtl/mdu_core.sv
module mdu_core
  import mdu_pkg::*;
#(
  parameter int unsigned XW = XLEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_op_i,
  input  logic [XW-1:0] cmd_a_i,
  input  logic [XW-1:0] cmd_b_i,
  input  logic          rd_req_i,
  input  logic          rd_sel_i,
  output logic [XW-1:0] rd_data_o,
  output logic          stall_o,
  output logic          busy_o
);

  localparam int unsigned HW = XW / 2;
  localparam int unsigned PW = 2 * XW;

  function automatic logic [XW-1:0] sext_half(logic [HW-1:0] v);
    return {{HW{v[HW-1]}}, v};
  endfunction

  function automatic logic [XW-1:0] widen(logic [XW-1:0] v, mdu_op_t op);
    logic [XW-1:0] r;
    if (op.dword)    r = v;
    else if (op.uns) r = {{HW{1'b0}}, v[HW-1:0]};
    else             r = sext_half(v[HW-1:0]);
    return r;
  endfunction

  mdu_op_t       op_in, op_q;
  logic [XW-1:0] ext_a, ext_b, mag_a, mag_b;
  logic          neg_a, neg_b, neg_a_q, neg_b_q;
  logic [XW-1:0] hi_q, lo_q, hi_d, lo_d;
  logic          fire, mul_run, div_run;
  logic [PW-1:0] prod, sprod;
  logic [XW-1:0] quo, rem, squo, srem;

  assign op_in = mdu_op_t'(cmd_op_i);
  assign ext_a = widen(cmd_a_i, op_in);
  assign ext_b = widen(cmd_b_i, op_in);
  assign neg_a = !op_in.uns && ext_a[XW-1];
  assign neg_b = !op_in.uns && ext_b[XW-1];
  assign mag_a = neg_a ? -ext_a : ext_a;
  assign mag_b = neg_b ? -ext_b : ext_b;

  mdu_lat_timer #(.LW(LAT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (cmd_valid_i),
    .lat_i   (op_latency(op_in)),
    .busy_o  (busy_o),
    .fire_o  (fire)
  );

  mdu_mul_engine #(.W(XW), .DIG(MUL_DIGIT)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd_valid_i && !op_in.is_div),
    .a_i     (mag_a),
    .b_i     (mag_b),
    .run_o   (mul_run),
    .prod_o  (prod)
  );

  mdu_div_engine #(.W(XW)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd_valid_i && op_in.is_div),
    .half_i  (!op_in.dword),
    .dvd_i   (mag_a),
    .dvs_i   (mag_b),
    .run_o   (div_run),
    .quo_o   (quo),
    .rem_o   (rem)
  );

  // sign restore and placement into the result pair
  always_comb begin
    sprod = (neg_a_q ^ neg_b_q) ? -prod : prod;
    squo  = (neg_a_q ^ neg_b_q) ? -quo : quo;
    srem  = neg_a_q ? -rem : rem;
    if (op_q.is_div) begin
      hi_d = op_q.dword ? srem : sext_half(srem[HW-1:0]);
      lo_d = op_q.dword ? squo : sext_half(squo[HW-1:0]);
    end else if (op_q.dword) begin
      hi_d = sprod[PW-1:XW];
      lo_d = sprod[XW-1:0];
    end else begin
      hi_d = sext_half(sprod[XW-1:HW]);
      lo_d = sext_half(sprod[HW-1:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      neg_a_q <= 1'b0;
      neg_b_q <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      if (cmd_valid_i) begin
        op_q    <= op_in;
        neg_a_q <= neg_a;
        neg_b_q <= neg_b;
      end
      if (fire) begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
    end
  end

  assign stall_o   = rd_req_i && busy_o;
  assign rd_data_o = rd_sel_i ? hi_q : lo_q;

  AST_ENGINE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |-> (op_q.is_div ? !div_run : !mul_run)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !cmd_valid_i) |=> ($stable(hi_q) && $stable(lo_q))); // R12
  AST_IDLE_NOSTALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !stall_o); // R8

endmodule

// File: tb/mdu_core_test.sv
module mdu_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [63:0] cmd_a = '0, cmd_b = '0;
  logic        rd_req = 1'b0, rd_sel = 1'b0;
  logic [63:0] rd_data;
  logic        stall, busy;

  always #5 clk = ~clk;

  mdu_core uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_a_i(cmd_a), .cmd_b_i(cmd_b), .rd_req_i(rd_req), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .stall_o(stall), .busy_o(busy)
  );

  typedef struct {
    logic [63:0] hi;
    logic [63:0] lo;
    int          lat;
    string       vreq;
    string       lreq;
  } exp_t;

  exp_t sb_q[$];
  int   errors = 0;
  int   total = 0;
  int   done_cnt = 0;

  function automatic logic [63:0] sx(logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ref_calc(input logic [2:0] op, input logic [63:0] a, b,
                          output logic [63:0] hi, output logic [63:0] lo, output int lat);
    logic [127:0] p;
    logic [63:0]  p64;
    logic [31:0]  q32, r32;
    hi = '0; lo = '0; lat = 0;
    case (op)
      3'b000: begin
        p64 = $signed({{32{a[31]}}, a[31:0]}) * $signed({{32{b[31]}}, b[31:0]});
        hi = sx(p64[63:32]); lo = sx(p64[31:0]); lat = 12;
      end
      3'b001: begin
        p64 = {32'd0, a[31:0]} * {32'd0, b[31:0]};
        hi = sx(p64[63:32]); lo = sx(p64[31:0]); lat = 12;
      end
      3'b100: begin
        p = {{64{a[63]}}, a} * {{64{b[63]}}, b};
        hi = p[127:64]; lo = p[63:0]; lat = 20;
      end
      3'b101: begin
        p = {64'd0, a} * {64'd0, b};
        hi = p[127:64]; lo = p[63:0]; lat = 20;
      end
      3'b010: begin
        q32 = $signed(a[31:0]) / $signed(b[31:0]);
        r32 = $signed(a[31:0]) % $signed(b[31:0]);
        hi = sx(r32); lo = sx(q32); lat = 75;
      end
      3'b011: begin
        q32 = a[31:0] / b[31:0];
        r32 = a[31:0] % b[31:0];
        hi = sx(r32); lo = sx(q32); lat = 75;
      end
      3'b110: begin
        lo = $signed(a) / $signed(b);
        hi = $signed(a) % $signed(b);
        lat = 139;
      end
      default: begin
        if (b == '0) begin lo = '1; hi = a; end
        else begin lo = a / b; hi = a % b; end
        lat = 139;
      end
    endcase
  endtask

  task automatic issue(logic [2:0] op, logic [63:0] a, b);
    cmd_op = op; cmd_a = a; cmd_b = b; cmd_valid = 1'b1;
    @(posedge clk); #2;
    cmd_valid = 1'b0;
  endtask

  task automatic run_op(logic [2:0] op, logic [63:0] a, b, string vreq, string lreq);
    exp_t e;
    int   seen;
    ref_calc(op, a, b, e.hi, e.lo, e.lat);
    e.vreq = vreq; e.lreq = lreq;
    seen = done_cnt;
    @(posedge clk); #2;
    sb_q.push_back(e);
    issue(op, a, b);
    while (done_cnt == seen) @(posedge clk);
  endtask

  // driver
  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    run_op(3'b000, {32'hDEAD_BEEF, 32'hFFFF_FFF9}, {32'h1234_5678, 32'd123456}, "R2", "R3");
    run_op(3'b000, 64'h7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, "R4", "R3");
    run_op(3'b001, 64'hFFFF_FFFF, 64'hAAAA_0000_FFFF_FFFF, "R4", "R3");
    run_op(3'b100, -64'sd3, 64'd5, "R5", "R3");
    run_op(3'b101, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_0000_0002, "R5", "R3");
    run_op(3'b100, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R5", "R3");
    run_op(3'b010, 64'hFFFF_FFEF, 64'd5, "R6", "R3");
    run_op(3'b011, 64'hFFFF_FFF0, 64'd7, "R6", "R3");
    run_op(3'b110, 64'd1000, -64'sd7, "R6", "R3");
    run_op(3'b110, -64'sd1000, 64'd7, "R6", "R3");
    run_op(3'b111, 64'hF000_0000_0000_0001, 64'd3, "R6", "R3");
    run_op(3'b111, 64'h0000_0123_4567_89AB, 64'd0, "R11", "R11");
    // R10: abort a long divide with a short multiply
    @(posedge clk); #2;
    issue(3'b110, 64'd999_999, 64'd3);
    repeat (4) @(posedge clk);
    run_op(3'b000, 64'd77, 64'd3, "R10", "R10");
    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  // monitor / scoreboard
  initial begin
    exp_t e;
    int   n, bad_stall, bad_nostall;
    @(posedge rst_n);
    @(negedge clk);
    chk("R1", "busy after reset", 64'(busy), 64'd0);
    chk("R1", "stall after reset", 64'(stall), 64'd0);
    rd_req = 1'b1; rd_sel = 1'b1; #1;
    chk("R1", "hi after reset", rd_data, 64'd0);
    rd_sel = 1'b0; #1;
    chk("R1", "lo after reset", rd_data, 64'd0);
    rd_req = 1'b0;
    forever begin
      while (sb_q.size() == 0) @(negedge clk);
      e = sb_q.pop_front();
      @(negedge clk);
      while (!busy) @(negedge clk);
      n = 0; bad_stall = 0; bad_nostall = 0;
      while (busy) begin
        if (rd_req && !stall) bad_stall++;
        if (!rd_req && stall) bad_nostall++;
        n++;
        if (n == 3) begin rd_req = 1'b1; rd_sel = 1'b1; end
        @(negedge clk);
      end
      chk(e.lreq, "busy cycles", 64'(n), 64'(e.lat));
      chk("R7", "cycles read without stall", 64'(bad_stall), 64'd0);
      chk("R9", "cycles stalled without read", 64'(bad_nostall), 64'd0);
      chk("R8", "stall once idle", 64'(stall), 64'd0);
      chk(e.vreq, "hi after stall", rd_data, e.hi);
      rd_sel = 1'b0; #1;
      chk(e.vreq, "lo idle read", rd_data, e.lo);
      rd_req = 1'b0;
      repeat (3) @(negedge clk);
      rd_req = 1'b1; rd_sel = 1'b1; #1;
      chk("R12", "hi held", rd_data, e.hi);
      rd_sel = 1'b0; #1;
      chk("R12", "lo held", rd_data, e.lo);
      rd_req = 1'b0;
      done_cnt++;
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL R3 watchdog: completed=%0d expected=13", done_cnt);
    $display("Result: errors=%0d of %0d checks", errors + 1, total + 1);
    $finish;
  end

endmodule